// File: doc/BRIEF.md
# Ready-Stall and Single-Step Controller

This block sits next to a small 8-bit processor core that runs on a single-phase clock. It turns an external, asynchronous ready level into a registered stall enable for the core. A ready that drops during a write is not honoured there; the stall is carried forward to the next read. While the core is held, the controller keeps a registered copy of the bus address and of the opcode-fetch marker (`sync_out`) frozen, so the outside world keeps seeing the cycle that is waiting.

A debug mode reuses the same path. With `step_en` high, every opcode-fetch read is held as if ready were low. Each rising edge on the asynchronous `step_req` input is synchronised, edge-detected and stored as one step credit. A credit lets exactly one opcode fetch through. The datapath, memory and any bus arbitration belong to the surrounding core and are not modelled here.

While reset is active, every ready stage holds its "ready" value, so the reset sequence that follows is never stalled.

Top module: `ready_step_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_stall`, `sync_out` and `addr_out` are 0 whatever `ext_rdy` does, and the ready synchroniser starts from the ready (high) state.
- R2: With `core_rw`=1 (read), a fall of `ext_rdy` raises `core_stall` on the (RDY_STAGES+1)-th rising clock edge after the fall, and not before.
- R3: With `core_rw`=0 (write), `core_stall` is never raised on behalf of ready, however long `ext_rdy` stays low.
- R4: A low synchronised ready seen during a write cycle is remembered. The next read cycle is stalled for at least one cycle even if ready has already returned high, and that read clears the memory.
- R5: A stall ends on the (RDY_STAGES+1)-th rising edge after `ext_rdy` rises, provided no deferred or step hold applies.
- R6: While `core_stall` is high, `addr_out` keeps the address captured when the stall began, even if `core_addr` changes. Once the stall ends, it follows `core_addr` one edge later.
- R7: `sync_out` is the registered copy of `core_fetch` one edge later, and it stays high for as long as a stalled opcode fetch is held.
- R8: With `step_en`=1, an opcode-fetch read (`core_fetch`=1, `core_rw`=1) is held with `core_stall` high until a step credit exists. Non-fetch reads are not held by step mode.
- R9: One step credit releases exactly one opcode fetch; the next fetch is held again. A credit that arrives before any fetch is stored and releases the next fetch without a stall.
- R10: `step_req` passes through STEP_STAGES synchronising flops and an edge detector. A held-high level gives only one credit, and a fetch held before the rise is released STEP_STAGES+2 edges after it.
- R11: With `step_en`=0, fetches are not held, and step edges arriving then are discarded rather than stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_rdy | input | 1 | Asynchronous external ready level, high = proceed |
| core_rw | input | 1 | Core bus direction, 1 = read, 0 = write |
| core_fetch | input | 1 | Core marks the current cycle as an opcode fetch |
| core_addr | input | ADDR_W | Core bus address |
| step_en | input | 1 | Enables single-instruction stepping |
| step_req | input | 1 | Asynchronous step request; each rising edge grants one step |
| core_stall | output | 1 | Registered stall enable to the core |
| sync_out | output | 1 | Registered opcode-fetch indication, frozen during a stall |
| addr_out | output | ADDR_W | Registered address, frozen during a stall |

## Verification
The bench builds the controller with ADDR_W=16, RDY_STAGES=2 and STEP_STAGES=3. The two synchroniser chains therefore differ in depth. This separates the ready latency (three edges) from the step release latency (five edges), so an off-by-one in either chain, or the two chains being swapped, lands on a different edge from the one the bench samples. The 16-bit address allows distinct patterns before and during a stall, so a hold failure shows up in the address value.

// File: rtl/rdyctl_pkg.sv
package rdyctl_pkg;

    typedef enum logic {
        BUS_WRITE = 1'b0,
        BUS_READ  = 1'b1
    } bus_dir_e;

    typedef struct packed {
        logic stall;
        logic pend;
        logic credit;
    } gate_regs_t;

endpackage

// File: rtl/rdyctl_cdc.sv
module rdyctl_cdc #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= RESET_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q = chain_q[LAST];
endmodule

// File: rtl/rdyctl_edge.sv
module rdyctl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        pulse  = lvl & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // A held level must produce a single grant.
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/rdyctl_gate.sv
module rdyctl_gate
    import rdyctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_ok,
    input  logic rw,
    input  logic fetch,
    input  logic step_en,
    input  logic step_pulse,
    output logic stall
);
    gate_regs_t cur_q, nxt_d;
    bus_dir_e   dir;
    logic       is_rd;
    logic       step_hold;
    logic       fetch_free;

    always_comb begin
        dir        = bus_dir_e'(rw);
        is_rd      = (dir == BUS_READ);
        step_hold  = step_en && fetch && !cur_q.credit;
        nxt_d      = cur_q;

        nxt_d.stall = is_rd && (!rdy_ok || cur_q.pend || step_hold);

        if (is_rd)        nxt_d.pend = 1'b0;
        else if (!rdy_ok) nxt_d.pend = 1'b1;

        fetch_free   = is_rd && fetch && step_en && !nxt_d.stall;
        nxt_d.credit = step_en && (step_pulse || (cur_q.credit && !fetch_free));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign stall = cur_q.stall;
endmodule

// File: rtl/rdyctl_bus.sv
module rdyctl_bus #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              fetch_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              sync_out
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              sync;
    } view_t;

    view_t view_d, view_q;

    always_comb begin
        view_d = view_q;
        if (!freeze) begin
            view_d.addr = addr_in;
            view_d.sync = fetch_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) view_q <= '0;
        else        view_q <= view_d;
    end

    assign addr_out = view_q.addr;
    assign sync_out = view_q.sync;
endmodule

// File: rtl/ready_step_ctrl.sv
module ready_step_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int RDY_STAGES  = 2,
    parameter int STEP_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rdy,
    input  logic              core_rw,
    input  logic              core_fetch,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              step_en,
    input  logic              step_req,
    output logic              core_stall,
    output logic              sync_out,
    output logic [ADDR_W-1:0] addr_out
);
    logic rdy_s;
    logic step_s;
    logic step_pulse;

    rdyctl_cdc #(.WIDTH(1), .STAGES(RDY_STAGES), .RESET_VAL(1'b1)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_rdy), .q(rdy_s));

    rdyctl_cdc #(.WIDTH(1), .STAGES(STEP_STAGES), .RESET_VAL(1'b0)) u_step_sync (
        .clk(clk), .rst_n(rst_n), .d(step_req), .q(step_s));

    rdyctl_edge u_step_edge (
        .clk(clk), .rst_n(rst_n), .lvl(step_s), .pulse(step_pulse));

    rdyctl_gate u_gate (
        .clk(clk), .rst_n(rst_n), .rdy_ok(rdy_s), .rw(core_rw),
        .fetch(core_fetch), .step_en(step_en), .step_pulse(step_pulse),
        .stall(core_stall));

    rdyctl_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .freeze(core_stall), .addr_in(core_addr),
        .fetch_in(core_fetch), .addr_out(addr_out), .sync_out(sync_out));

    // A read seen with synchronised ready low must be stalled next cycle.
    assert_read_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rw && !rdy_s) |=> core_stall);

    // A stall is only ever raised on a cycle that was a read.
    assert_no_write_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> $past(core_rw));

    // The bus view is frozen while stalled.
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |=> $stable(addr_out));

    // A held opcode fetch keeps its marker.
    assert_sync_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_stall && sync_out) |=> sync_out);
endmodule

// File: tb/sim_ready_step_ctrl.sv
`timescale 1ns/1ps
module sim_ready_step_ctrl;
    localparam int AW  = 16;
    localparam int RS  = 2;
    localparam int SS  = 3;
    localparam int RL  = RS + 1;
    localparam int SL  = SS + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_rdy = 1'b1;
    logic          core_rw = 1'b1;
    logic          core_fetch = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic          step_en = 1'b0;
    logic          step_req = 1'b0;
    logic          core_stall;
    logic          sync_out;
    logic [AW-1:0] addr_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ready_step_ctrl #(.ADDR_W(AW), .RDY_STAGES(RS), .STEP_STAGES(SS)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_rdy(ext_rdy), .core_rw(core_rw),
        .core_fetch(core_fetch), .core_addr(core_addr), .step_en(step_en),
        .step_req(step_req), .core_stall(core_stall), .sync_out(sync_out),
        .addr_out(addr_out));

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        ext_rdy = 1'b0; core_rw = 1'b1; core_fetch = 1'b1; core_addr = 16'hA5A5;
        tick(4);
        chk("R1 stall in reset", core_stall, 0);
        chk("R1 sync in reset", sync_out, 0);
        chk("R1 addr in reset", addr_out, 0);
        ext_rdy = 1'b1; core_fetch = 1'b0; core_addr = 16'h0000;
        tick(RL);
        rst_n = 1'b1;
        tick(1);
        chk("R1 no stall after release", core_stall, 0);
    endtask

    task automatic t_read_stall;
        core_rw = 1'b1; core_fetch = 1'b0; core_addr = 16'h1234;
        tick(1);
        ext_rdy = 1'b0;
        tick(RL - 1);
        chk("R2 not yet stalled", core_stall, 0);
        tick(1);
        chk("R2 stalled", core_stall, 1);
        chk("R6 captured addr", addr_out, 16'h1234);
        core_addr = 16'h5678;
        tick(2);
        chk("R6 addr held", addr_out, 16'h1234);
        chk("R2 still stalled", core_stall, 1);
        ext_rdy = 1'b1;
        tick(RL - 1);
        chk("R5 held until sync", core_stall, 1);
        tick(1);
        chk("R5 stall released", core_stall, 0);
        chk("R6 addr still old", addr_out, 16'h1234);
        tick(1);
        chk("R6 addr follows", addr_out, 16'h5678);
    endtask

    task automatic t_write_defer;
        core_rw = 1'b0; core_addr = 16'h2000;
        ext_rdy = 1'b0;
        tick(RL);
        chk("R3 write not stalled", core_stall, 0);
        tick(3);
        chk("R3 write long low", core_stall, 0);
        core_rw = 1'b1; core_addr = 16'h2001;
        tick(1);
        chk("R4 next read stalled", core_stall, 1);
        ext_rdy = 1'b1;
        tick(RL);
        chk("R5 read released", core_stall, 0);
        // low ready seen in write, ready back high before the read
        core_rw = 1'b0;
        ext_rdy = 1'b0;
        tick(RL);
        ext_rdy = 1'b1;
        tick(RL);
        chk("R3 write ignores ready", core_stall, 0);
        core_rw = 1'b1;
        tick(1);
        chk("R4 deferred minimum stall", core_stall, 1);
        tick(1);
        chk("R4 deferral cleared", core_stall, 0);
        tick(2);
        chk("R4 no repeat", core_stall, 0);
    endtask

    task automatic t_sync;
        core_rw = 1'b1; core_fetch = 1'b1; core_addr = 16'h3000;
        tick(1);
        chk("R7 sync on fetch", sync_out, 1);
        chk("R7 fetch not stalled", core_stall, 0);
        core_fetch = 1'b0; core_addr = 16'h3001;
        tick(1);
        chk("R7 sync off", sync_out, 0);
        core_fetch = 1'b1; core_addr = 16'h3002;
        ext_rdy = 1'b0;
        tick(RL);
        chk("R7 stalled fetch", core_stall, 1);
        core_fetch = 1'b0;
        tick(2);
        chk("R7 sync held in stall", sync_out, 1);
        ext_rdy = 1'b1;
        tick(RL + 1);
        chk("R7 sync drops after stall", sync_out, 0);
    endtask

    task automatic t_step;
        step_en = 1'b1; core_rw = 1'b1; core_fetch = 1'b1; core_addr = 16'h4000;
        tick(1);
        chk("R8 fetch held", core_stall, 1);
        chk("R8 sync shown", sync_out, 1);
        tick(3);
        chk("R8 still held", core_stall, 1);
        step_req = 1'b1;
        tick(SL - 1);
        chk("R10 not before latency", core_stall, 1);
        tick(1);
        chk("R9 released", core_stall, 0);
        core_fetch = 1'b0; core_addr = 16'h4001;
        tick(1);
        chk("R8 plain read free", core_stall, 0);
        core_fetch = 1'b1; core_addr = 16'h4002;
        tick(1);
        chk("R9 next fetch held", core_stall, 1);
        tick(SL + 2);
        chk("R10 level gives one step", core_stall, 1);
        step_req = 1'b0;
        tick(SL);
        step_req = 1'b1;
        tick(SL);
        chk("R10 second step released", core_stall, 0);
        core_fetch = 1'b0;
        step_req = 1'b0;
        tick(SL);
        // credit before the fetch
        step_req = 1'b1;
        tick(SL);
        core_fetch = 1'b1; core_addr = 16'h4003;
        tick(1);
        chk("R9 stored credit frees fetch", core_stall, 0);
        core_fetch = 1'b1; core_addr = 16'h4004;
        tick(1);
        chk("R9 credit used once", core_stall, 1);
    endtask

    task automatic t_step_off;
        step_req = 1'b0;
        step_en = 1'b0;
        core_fetch = 1'b1;
        tick(1);
        chk("R11 no hold when disabled", core_stall, 0);
        tick(SL);
        step_req = 1'b1;
        tick(SL + 1);
        chk("R11 fetch free while off", core_stall, 0);
        step_en = 1'b1;
        tick(1);
        chk("R11 step discarded", core_stall, 1);
        step_en = 1'b0;
        tick(1);
        chk("R11 hold drops when off", core_stall, 0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_read_stall();
        t_write_defer();
        t_sync();
        t_step();
        t_step_off();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule